// File: doc/BRIEF.md
# Display Pixel Format Unpacker

This block sits between the memory fetch of one display layer and the rest of the pixel pipeline. It accepts a stream of 32-bit memory words over a valid/ready handshake. It emits one pixel per accepted output handshake, and each pixel carries four 16-bit channels: alpha, red, green and blue. A 6-bit format code selects how the bits of the stream are cut into pixels. The supported layouts are packed RGB at 16, 24, 32 and 64 bits per pixel, and palette-index bitmaps at 1, 2, 4 and 8 bits per pixel. Bitmap pixels leave the block as raw indices, ready for a palette lookup further down the pipeline.

The layer controller pulses `frame_start` once per frame and presents the format code and the nibble-order control in that same cycle. The block latches both values and empties its bit store. From then on it treats the stream as one continuous little-endian bit sequence. Pixels are taken from the least significant end first, so a 24-bit pixel may span two input words and a 64-bit pixel always takes two words. A code that the block does not support raises an error flag. The block then consumes input words without producing pixels.

Top module: `pxu_unpacker`

## Requirements
- R1: `fmt_code` and `nibble_mode` are sampled only in a cycle with `frame_start` high; changes at other times have no effect. In the `frame_start` cycle `in_ready` and `out_valid` are both low, and all bits held from earlier words are discarded.
- R2: 16-bit codes take two pixels per word, low half first. Layouts, most significant field first: 0x00 A4R4G4B4, 0x01 A4B4G4R4, 0x02 R4G4B4A4, 0x03 R5G6B5, 0x04 B5G6R5, 0x05 A1R5G5B5, 0x06 A1B5G5R5.
- R3: 32-bit codes take one pixel per word: 0x07 A8R8G8B8, 0x08 A8B8G8R8, 0x09 R8G8B8A8, 0x0A B8G8R8A8, 0x0E A2R10G10B10, 0x0F A2B10G10R10.
- R4: 24-bit codes 0x0B R8G8B8 and 0x0C B8G8R8 read the stream as a continuous byte sequence, lowest byte first. Four words yield exactly five pixels, and the remaining byte is carried into the next pixel.
- R5: 64-bit codes 0x10 A16R16G16B16 and 0x11 R16G16B16A16 take two words per pixel, and the first word holds the low 32 bits.
- R6: A field narrower than 16 bits is widened by repeating its bit pattern from the MSB downward, so a 1-bit alpha gives 0x0000 or 0xFFFF.
- R7: A code equal to an alpha-carrying code from R2, R3 or R5 plus 0x20 unpacks the same layout, but the output alpha is always 0xFFFF.
- R8: Codes without an alpha field (0x03, 0x04, 0x0B, 0x0C) output alpha 0xFFFF.
- R9: Codes 0x12, 0x13, 0x14 and 0x15 are bitmaps of 1, 2, 4 and 8 bits per pixel. The index appears zero-extended on `out_blue`, with red and green at 0 and alpha at 0xFFFF. Without nibble mode, pixels are taken from the low end of each byte first.
- R10: With nibble mode latched, sub-byte bitmap pixels are taken from the high end of each byte first. For 8-bit bitmaps and non-bitmap codes, nibble mode has no effect.
- R11: Any other code, including 0x0D, 0x16 to 0x1F and the plus-0x20 forms of codes without alpha (0x23, 0x24, 0x2B, 0x2C, 0x32 and above), sets `fmt_error`. While it is set, `in_ready` is high, `out_valid` is low, and words are dropped.
- R12: While `out_valid` is high and `out_ready` is low, the pixel on the outputs holds. No pixel is lost or repeated across stalls on either side.
- R13: After reset, `out_valid` and `fmt_error` are low, `in_ready` is high, and code 0x00 is in force without nibble mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | Frame boundary: latch format, clear stored bits |
| fmt_code | input | 6 | Pixel format selector |
| nibble_mode | input | 1 | Reverse sub-byte bitmap pixel order |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block accepts the input word |
| in_data | input | 32 | Memory word |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Consumer takes the pixel |
| out_alpha | output | 16 | Alpha channel |
| out_red | output | 16 | Red channel |
| out_green | output | 16 | Green channel |
| out_blue | output | 16 | Blue channel, or bitmap index |
| fmt_error | output | 1 | Latched format is unsupported |

## Verification
The hardest case to reach from the ports is a frame boundary that arrives while bits of an unfinished pixel are still held. If stale bits survived the boundary, they would shift every later pixel. The stimulus feeds two words of a 24-bit format, which leaves 16 bits behind, and then restarts the frame with four fresh words. It requires exactly five pixels, where six would appear if the old bits had been kept. Random stalls on both handshakes, together with format codes changed between frame pulses, exercise the hold and latching rules against a bit-queue reference model.

// File: rtl/pxu_pkg.sv
// Shared types and helpers for the pixel format unpacker.
// Assumes a 32-bit input word, a 64-bit bit store and 16-bit channels.
package pxu_pkg;
    localparam int PXU_WORD_W = 32;
    localparam int PXU_BUF_W  = 64;
    localparam int PXU_CH_W   = 16;
    localparam int PXU_CNT_W  = $clog2(PXU_BUF_W + 1);

    // One colour field: position of its LSB inside the pixel and its width (0 = absent)
    typedef struct packed {
        logic [5:0] lsb;
        logic [4:0] wid;
    } pxu_fld_t;

    // Everything the datapath needs to know about the active format
    typedef struct packed {
        logic                 ok;
        logic                 bitmap;
        logic                 alpha_ign;
        logic [PXU_CNT_W-1:0] bpp;
        pxu_fld_t             fa;
        pxu_fld_t             fr;
        pxu_fld_t             fg;
        pxu_fld_t             fb;
    } pxu_desc_t;

    // Build a field descriptor
    function automatic pxu_fld_t pxu_fld(input int lsb, input int wid);
        pxu_fld_t f;
        f.lsb = 6'(lsb);
        f.wid = 5'(wid);
        return f;
    endfunction

    // Translate a format code into a layout descriptor
    function automatic pxu_desc_t pxu_decode(input logic [5:0] code);
        pxu_desc_t d;
        logic      has_a;
        d    = '0;
        d.ok = 1'b1;
        case (code[4:0])
            5'h00: begin d.bpp = 7'd16; d.fa = pxu_fld(12,4); d.fr = pxu_fld(8,4);  d.fg = pxu_fld(4,4);  d.fb = pxu_fld(0,4);  end
            5'h01: begin d.bpp = 7'd16; d.fa = pxu_fld(12,4); d.fb = pxu_fld(8,4);  d.fg = pxu_fld(4,4);  d.fr = pxu_fld(0,4);  end
            5'h02: begin d.bpp = 7'd16; d.fr = pxu_fld(12,4); d.fg = pxu_fld(8,4);  d.fb = pxu_fld(4,4);  d.fa = pxu_fld(0,4);  end
            5'h03: begin d.bpp = 7'd16; d.fr = pxu_fld(11,5); d.fg = pxu_fld(5,6);  d.fb = pxu_fld(0,5);  end
            5'h04: begin d.bpp = 7'd16; d.fb = pxu_fld(11,5); d.fg = pxu_fld(5,6);  d.fr = pxu_fld(0,5);  end
            5'h05: begin d.bpp = 7'd16; d.fa = pxu_fld(15,1); d.fr = pxu_fld(10,5); d.fg = pxu_fld(5,5);  d.fb = pxu_fld(0,5);  end
            5'h06: begin d.bpp = 7'd16; d.fa = pxu_fld(15,1); d.fb = pxu_fld(10,5); d.fg = pxu_fld(5,5);  d.fr = pxu_fld(0,5);  end
            5'h07: begin d.bpp = 7'd32; d.fa = pxu_fld(24,8); d.fr = pxu_fld(16,8); d.fg = pxu_fld(8,8);  d.fb = pxu_fld(0,8);  end
            5'h08: begin d.bpp = 7'd32; d.fa = pxu_fld(24,8); d.fb = pxu_fld(16,8); d.fg = pxu_fld(8,8);  d.fr = pxu_fld(0,8);  end
            5'h09: begin d.bpp = 7'd32; d.fr = pxu_fld(24,8); d.fg = pxu_fld(16,8); d.fb = pxu_fld(8,8);  d.fa = pxu_fld(0,8);  end
            5'h0A: begin d.bpp = 7'd32; d.fb = pxu_fld(24,8); d.fg = pxu_fld(16,8); d.fr = pxu_fld(8,8);  d.fa = pxu_fld(0,8);  end
            5'h0B: begin d.bpp = 7'd24; d.fr = pxu_fld(16,8); d.fg = pxu_fld(8,8);  d.fb = pxu_fld(0,8);  end
            5'h0C: begin d.bpp = 7'd24; d.fb = pxu_fld(16,8); d.fg = pxu_fld(8,8);  d.fr = pxu_fld(0,8);  end
            5'h0E: begin d.bpp = 7'd32; d.fa = pxu_fld(30,2); d.fr = pxu_fld(20,10); d.fg = pxu_fld(10,10); d.fb = pxu_fld(0,10); end
            5'h0F: begin d.bpp = 7'd32; d.fa = pxu_fld(30,2); d.fb = pxu_fld(20,10); d.fg = pxu_fld(10,10); d.fr = pxu_fld(0,10); end
            5'h10: begin d.bpp = 7'd64; d.fa = pxu_fld(48,16); d.fr = pxu_fld(32,16); d.fg = pxu_fld(16,16); d.fb = pxu_fld(0,16); end
            5'h11: begin d.bpp = 7'd64; d.fr = pxu_fld(48,16); d.fg = pxu_fld(32,16); d.fb = pxu_fld(16,16); d.fa = pxu_fld(0,16); end
            5'h12: begin d.bpp = 7'd1;  d.bitmap = 1'b1; d.fb = pxu_fld(0,1); end
            5'h13: begin d.bpp = 7'd2;  d.bitmap = 1'b1; d.fb = pxu_fld(0,2); end
            5'h14: begin d.bpp = 7'd4;  d.bitmap = 1'b1; d.fb = pxu_fld(0,4); end
            5'h15: begin d.bpp = 7'd8;  d.bitmap = 1'b1; d.fb = pxu_fld(0,8); end
            default: d.ok = 1'b0;
        endcase
        has_a = (d.fa.wid != 5'd0);
        if (code[5]) begin
            if (!has_a) d.ok = 1'b0;
            d.alpha_ign = 1'b1;
            d.fa        = pxu_fld(0,0);
        end
        if (!d.ok) d = '0;
        return d;
    endfunction

    // Widen a w-bit value to 16 bits by repeating its pattern from the MSB down
    function automatic logic [PXU_CH_W-1:0] pxu_widen(input logic [PXU_CH_W-1:0] v,
                                                      input logic [4:0] w);
        logic [31:0] r;
        int          s;
        if (w == 5'd0) return '1;
        s = int'(w);
        r = 32'(v) << (32 - s);
        r = r | (r >> s);
        r = r | (r >> (2 * s));
        r = r | (r >> (4 * s));
        r = r | (r >> (8 * s));
        return r[31:16];
    endfunction

    // Reverse the order of sub-byte pixel groups inside every byte of a word
    function automatic logic [PXU_WORD_W-1:0] pxu_regroup(input logic [PXU_WORD_W-1:0] w,
                                                          input logic [PXU_CNT_W-1:0] bpp);
        logic [PXU_WORD_W-1:0] r;
        r = w;
        for (int by = 0; by < PXU_WORD_W / 8; by++) begin
            for (int i = 0; i < 8; i++) begin
                case (bpp)
                    7'd1:    r[by*8+i] = w[by*8 + 7 - i];
                    7'd2:    r[by*8+i] = w[by*8 + 6 - (i/2)*2 + (i%2)];
                    7'd4:    r[by*8+i] = w[by*8 + ((i+4)%8)];
                    default: r[by*8+i] = w[by*8+i];
                endcase
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/pxu_fmt_ctrl.sv
// Format latch: samples the format code and nibble control on a frame-start
// pulse and holds the decoded layout for the rest of the frame.
// Assumes the controller presents a stable code during the pulse cycle.
module pxu_fmt_ctrl
    import pxu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic [5:0] fmt_code,
    input  logic       nibble_mode,
    output pxu_desc_t  desc,
    output logic       nib_en,
    output logic       fmt_err
);
    pxu_desc_t desc_q;
    logic      nib_q;

    // Capture decoded format and nibble control at each frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_q <= pxu_decode(6'h00);
            nib_q  <= 1'b0;
        end else if (frame_start) begin
            desc_q <= pxu_decode(fmt_code);
            nib_q  <= nibble_mode;
        end
    end

    // Nibble regrouping applies only to sub-byte bitmaps
    always_comb begin
        desc    = desc_q;
        nib_en  = nib_q && desc_q.bitmap && (desc_q.bpp < 7'd8);
        fmt_err = !desc_q.ok;
    end

    // R1
    fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(desc_q) && $stable(nib_q));
endmodule

// File: rtl/pxu_bit_buffer.sv
// Residue store: appends whole input words above the bits it holds and
// releases the lowest BPP bits as one pixel. Bits above the count are
// always zero. Assumes 0 < bpp <= BUF_W and BUF_W >= 2*WORD_W.
module pxu_bit_buffer #(
    parameter int WORD_W = 32,
    parameter int BUF_W  = 64,
    localparam int CNT_W = $clog2(BUF_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              drop,
    input  logic [CNT_W-1:0]  bpp,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BUF_W-1:0]  out_bits
);
    localparam logic [CNT_W-1:0] ROOM   = CNT_W'(BUF_W - WORD_W);
    localparam logic [CNT_W-1:0] WORD_C = CNT_W'(WORD_W);

    logic [BUF_W-1:0] store_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_after;
    logic             pop;
    logic             push;

    // Handshake decisions for this cycle
    always_comb begin
        out_valid = !clear && !drop && (cnt_q >= bpp);
        pop       = out_valid && out_ready;
        cnt_after = pop ? (cnt_q - bpp) : cnt_q;
        in_ready  = !clear && (drop || (cnt_after <= ROOM));
        push      = in_valid && in_ready && !drop;
        out_bits  = store_q;
    end

    // Shift out the taken pixel and append the accepted word
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            store_q <= '0;
            cnt_q   <= '0;
        end else begin
            store_q <= (pop ? (store_q >> bpp) : store_q)
                     | (push ? (BUF_W'(in_word) << cnt_after) : '0);
            cnt_q   <= cnt_after + (push ? WORD_C : '0);
        end
    end

    // R12
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(BUF_W));

    // R11
    drop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !clear) |-> (cnt_q == '0));
endmodule

// File: rtl/pxu_chan_expand.sv
// One output channel: picks a field out of the pixel bits and widens it
// to 16 bits, or passes it zero-extended when raw is set.
// Assumes field lsb + width stays inside the pixel.
module pxu_chan_expand
    import pxu_pkg::*;
#(
    parameter int PIX_W = 64
) (
    input  logic [PIX_W-1:0]    pix,
    input  pxu_fld_t            fld,
    input  logic                raw,
    output logic [PXU_CH_W-1:0] value
);
    logic [PXU_CH_W-1:0] field;
    logic [PXU_CH_W-1:0] mask;

    // Isolate the field and widen it
    always_comb begin
        mask  = PXU_CH_W'((17'd1 << fld.wid) - 17'd1);
        field = PXU_CH_W'(pix >> fld.lsb) & mask;
        value = raw ? field : pxu_widen(field, fld.wid);
    end
endmodule

// File: rtl/pxu_unpacker.sv
// Pixel format unpacker top: latches the format per frame, regroups
// bitmap bits for nibble mode, stores residue bits and expands four
// channels. One pixel per output handshake; input and output may
// transfer in the same cycle.
module pxu_unpacker
    import pxu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_start,
    input  logic [5:0]  fmt_code,
    input  logic        nibble_mode,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [15:0] out_alpha,
    output logic [15:0] out_red,
    output logic [15:0] out_green,
    output logic [15:0] out_blue,
    output logic        fmt_error
);
    localparam int NCH = 4;

    pxu_desc_t             desc;
    logic                  nib_en;
    logic                  fmt_err;
    logic [PXU_WORD_W-1:0] word_in;
    logic [PXU_BUF_W-1:0]  pix_bits;
    pxu_fld_t              flds [NCH];
    logic [PXU_CH_W-1:0]   ch_val [NCH];

    pxu_fmt_ctrl u_fmt (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .fmt_code    (fmt_code),
        .nibble_mode (nibble_mode),
        .desc        (desc),
        .nib_en      (nib_en),
        .fmt_err     (fmt_err)
    );

    // Reorder sub-byte bitmap groups before they enter the store
    always_comb word_in = nib_en ? pxu_regroup(in_data, desc.bpp) : in_data;

    pxu_bit_buffer #(
        .WORD_W (PXU_WORD_W),
        .BUF_W  (PXU_BUF_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (frame_start),
        .drop      (fmt_err),
        .bpp       (desc.bpp),
        .in_valid  (in_valid),
        .in_word   (word_in),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_bits  (pix_bits)
    );

    // Channel order: alpha, red, green, blue
    always_comb begin
        flds[0] = desc.fa;
        flds[1] = desc.fr;
        flds[2] = desc.fg;
        flds[3] = desc.fb;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pxu_chan_expand #(.PIX_W(PXU_BUF_W)) u_ch (
            .pix   (pix_bits),
            .fld   (flds[c]),
            .raw   ((c != 0) && desc.bitmap),
            .value (ch_val[c])
        );
    end

    // Drive the pixel outputs
    always_comb begin
        out_alpha = ch_val[0];
        out_red   = ch_val[1];
        out_green = ch_val[2];
        out_blue  = ch_val[3];
        fmt_error = fmt_err;
    end

    // R12
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> ((out_valid || frame_start) &&
            $stable({out_alpha, out_red, out_green, out_blue})));

    // R11
    err_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_error |-> (!out_valid && (in_ready || frame_start)));

    // R1
    fs_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (!in_ready && !out_valid));

    // R7
    alpha_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && desc.alpha_ign) |-> (out_alpha == 16'hFFFF));

    // R9
    bitmap_rg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && desc.bitmap) |-> (out_red == 16'h0 && out_green == 16'h0 &&
                                        out_alpha == 16'hFFFF));
endmodule

// File: tb/pxu_unpacker_tb_top.sv
// Bench: a bit-queue reference model fed with every accepted word,
// compared against every output handshake.
module pxu_unpacker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_start;
    logic [5:0]  fmt_code;
    logic        nibble_mode;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_data;
    logic        out_valid;
    logic        out_ready;
    logic [15:0] out_alpha, out_red, out_green, out_blue;
    logic        fmt_error;

    always #2 clk = ~clk;

    pxu_unpacker dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .fmt_code(fmt_code),
        .nibble_mode(nibble_mode), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_alpha(out_alpha), .out_red(out_red), .out_green(out_green),
        .out_blue(out_blue), .fmt_error(fmt_error)
    );

    int          checks = 0;
    int          fails  = 0;
    int          cyc    = 0;
    int          cur_code = 0;
    bit          cur_nib  = 0;
    bit          bq[$];
    logic [63:0] expq[$];
    int          npix;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit ref_ok(input int code);
        int base = code % 32;
        if (code >= 32)
            return (base <= 2) || (base >= 5 && base <= 10) || (base >= 14 && base <= 17);
        return (base <= 12) || (base >= 14 && base <= 21);
    endfunction

    function automatic int ref_bpp(input int code);
        int base = code % 32;
        if (base <= 6) return 16;
        if (base == 11 || base == 12) return 24;
        if (base <= 15) return 32;
        if (base <= 17) return 64;
        case (base)
            18: return 1;
            19: return 2;
            20: return 4;
            default: return 8;
        endcase
    endfunction

    function automatic string ref_req(input int code);
        int b = ref_bpp(code);
        if (code >= 32) return "R7";
        if (code % 32 >= 18) return "R9";
        if (b == 16) return "R2";
        if (b == 24) return "R4";
        if (b == 64) return "R5";
        return "R3";
    endfunction

    // Widen by indexing the source pattern modulo its width
    function automatic logic [15:0] ref_widen(input logic [63:0] v, input int w);
        logic [15:0] r;
        if (w == 0) return 16'hFFFF;
        for (int i = 0; i < 16; i++) r[15-i] = v[w - 1 - (i % w)];
        return r;
    endfunction

    function automatic logic [63:0] ref_get(input logic [63:0] v, input int lsb, input int w);
        return (v >> lsb) & ((64'd1 << w) - 64'd1);
    endfunction

    function automatic logic [63:0] ref_pixel(input int code, input logic [63:0] v);
        int base = code % 32;
        int al = 0, aw = 0, rl = 0, rw = 0, gl = 0, gw = 0, bl = 0, bw = 0;
        logic [15:0] a, r, g, b;
        if (base >= 18) return {16'hFFFF, 16'h0, 16'h0, ref_get(v, 0, ref_bpp(code))[15:0]};
        case (base)
            0:  begin aw=4; al=12; rw=4; rl=8;  gw=4; gl=4; bw=4; bl=0; end
            1:  begin aw=4; al=12; bw=4; bl=8;  gw=4; gl=4; rw=4; rl=0; end
            2:  begin rw=4; rl=12; gw=4; gl=8;  bw=4; bl=4; aw=4; al=0; end
            3:  begin rw=5; rl=11; gw=6; gl=5;  bw=5; bl=0; end
            4:  begin bw=5; bl=11; gw=6; gl=5;  rw=5; rl=0; end
            5:  begin aw=1; al=15; rw=5; rl=10; gw=5; gl=5; bw=5; bl=0; end
            6:  begin aw=1; al=15; bw=5; bl=10; gw=5; gl=5; rw=5; rl=0; end
            7:  begin aw=8; al=24; rw=8; rl=16; gw=8; gl=8; bw=8; bl=0; end
            8:  begin aw=8; al=24; bw=8; bl=16; gw=8; gl=8; rw=8; rl=0; end
            9:  begin rw=8; rl=24; gw=8; gl=16; bw=8; bl=8; aw=8; al=0; end
            10: begin bw=8; bl=24; gw=8; gl=16; rw=8; rl=8; aw=8; al=0; end
            11: begin rw=8; rl=16; gw=8; gl=8;  bw=8; bl=0; end
            12: begin bw=8; bl=16; gw=8; gl=8;  rw=8; rl=0; end
            14: begin aw=2; al=30; rw=10; rl=20; gw=10; gl=10; bw=10; bl=0; end
            15: begin aw=2; al=30; bw=10; bl=20; gw=10; gl=10; rw=10; rl=0; end
            16: begin aw=16; al=48; rw=16; rl=32; gw=16; gl=16; bw=16; bl=0; end
            default: begin rw=16; rl=48; gw=16; gl=32; bw=16; bl=16; aw=16; al=0; end
        endcase
        a = ref_widen(ref_get(v, al, aw), aw);
        r = ref_widen(ref_get(v, rl, rw), rw);
        g = ref_widen(ref_get(v, gl, gw), gw);
        b = ref_widen(ref_get(v, bl, bw), bw);
        if (code >= 32) a = 16'hFFFF;
        return {a, r, g, b};
    endfunction

    // Append an accepted word to the bit queue and form complete pixels
    task automatic model_push(input logic [31:0] w);
        int bpp = ref_bpp(cur_code);
        bit regroup = cur_nib && (cur_code >= 18) && (bpp < 8);
        logic [63:0] v;
        for (int by = 0; by < 4; by++) begin
            if (regroup) begin
                for (int g = 8 / bpp - 1; g >= 0; g--)
                    for (int k = 0; k < bpp; k++) bq.push_back(w[by*8 + g*bpp + k]);
            end else begin
                for (int k = 0; k < 8; k++) bq.push_back(w[by*8 + k]);
            end
        end
        while (bq.size() >= bpp) begin
            v = '0;
            for (int k = 0; k < bpp; k++) v[k] = bq.pop_front();
            expq.push_back(ref_pixel(cur_code, v));
        end
    endtask

    task automatic pulse_frame(input int code, input bit nib);
        @(negedge clk);
        frame_start = 1'b1;
        fmt_code    = 6'(code);
        nibble_mode = nib;
        in_valid    = 1'b1;
        out_ready   = 1'b1;
        #1;
        chk(!in_ready && !out_valid, "R1 frame_start stalls both sides",
            {62'd0, in_ready, out_valid}, 64'd0);
        cur_code = code;
        cur_nib  = nib;
        bq.delete();
        expq.delete();
        @(negedge clk);
        frame_start = 1'b0;
        in_valid    = 1'b0;
    endtask

    task automatic run_words(input int n);
        int  sent = 0;
        int  guard = 0;
        bit  err_bad = 0;
        logic [63:0] e;
        logic [63:0] act;
        npix = 0;
        while ((sent < n || expq.size() > 0) && guard < 3000) begin
            @(negedge clk);
            in_valid  = (sent < n) && ($urandom % 4 != 0);
            in_data   = $urandom;
            out_ready = ($urandom % 4 != 0);
            #1;
            if (!ref_ok(cur_code) && (out_valid || !fmt_error || !in_ready)) err_bad = 1;
            if (out_valid && out_ready) begin
                npix++;
                act = {out_alpha, out_red, out_green, out_blue};
                if (expq.size() == 0) begin
                    chk(0, "R12 pixel without data", act, 64'd0);
                end else begin
                    e = expq.pop_front();
                    chk(act == e, ref_req(cur_code), act, e);
                end
            end
            if (in_valid && in_ready) begin
                sent++;
                if (ref_ok(cur_code)) model_push(in_data);
            end
            guard++;
        end
        chk(guard < 3000, "R12 stream progress", 64'(guard), 64'd3000);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            out_ready = 1'b1;
            #1;
            if (out_valid) begin
                npix++;
                chk(0, "R12 extra pixel", {out_alpha, out_red, out_green, out_blue}, 64'd0);
            end
        end
        if (!ref_ok(cur_code))
            chk(!err_bad, "R11 error flag, ready high, no pixels", 64'(err_bad), 64'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int codes_ok[] = '{'h00, 'h01, 'h02, 'h03, 'h04, 'h05, 'h06, 'h07, 'h08, 'h09,
                           'h0A, 'h0B, 'h0C, 'h0E, 'h0F, 'h10, 'h11, 'h20, 'h21, 'h22,
                           'h25, 'h26, 'h27, 'h29, 'h2A, 'h2E, 'h2F, 'h30, 'h31};
        int codes_bad[] = '{'h0D, 'h16, 'h1F, 'h23, 'h24, 'h2B, 'h2C, 'h32, 'h35, 'h3F};
        rst_n = 1'b0; frame_start = 1'b0; fmt_code = '0; nibble_mode = 1'b0;
        in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R13 reset state
        chk(!out_valid, "R13 out_valid after reset", 64'(out_valid), 64'd0);
        chk(!fmt_error, "R13 fmt_error after reset", 64'(fmt_error), 64'd0);
        chk(in_ready, "R13 in_ready after reset", 64'(in_ready), 64'd1);
        // R13 default format in force without a frame pulse
        cur_code = 0; cur_nib = 0;
        run_words(6);
        chk(npix == 12, "R13 default 16-bit pixel count", 64'(npix), 64'd12);

        // R2 R3 R4 R5 R6 R7 R8 across all supported packed codes
        foreach (codes_ok[i]) begin
            pulse_frame(codes_ok[i], 1'b0);
            run_words(8);
        end

        // R9 bitmaps, low end first; R10 reversed within the byte
        for (int c = 'h12; c <= 'h15; c++) begin
            pulse_frame(c, 1'b0);
            run_words(5);
            pulse_frame(c, 1'b1);
            run_words(5);
        end
        // R10 nibble mode has no effect on non-bitmap codes
        pulse_frame('h07, 1'b1);
        run_words(4);
        pulse_frame('h0B, 1'b1);
        run_words(4);

        // R4 four words give exactly five pixels
        pulse_frame('h0C, 1'b0);
        run_words(4);
        chk(npix == 5, "R4 five pixels from four words", 64'(npix), 64'd5);
        // R5 two words per pixel
        pulse_frame('h10, 1'b0);
        run_words(6);
        chk(npix == 3, "R5 three pixels from six words", 64'(npix), 64'd3);

        // R1 residue discarded at a frame pulse: 16 leftover bits must not survive
        pulse_frame('h0B, 1'b0);
        run_words(2);
        pulse_frame('h0B, 1'b0);
        run_words(4);
        chk(npix == 5, "R1 residue cleared at frame_start", 64'(npix), 64'd5);

        // R1 code change without a frame pulse is ignored
        pulse_frame('h03, 1'b0);
        run_words(3);
        fmt_code = 6'h07;
        nibble_mode = 1'b1;
        run_words(5);
        chk(npix == 10, "R1 format held mid-frame", 64'(npix), 64'd10);

        // R11 unsupported codes
        foreach (codes_bad[i]) begin
            pulse_frame(codes_bad[i], 1'b0);
            run_words(4);
            chk(npix == 0, "R11 no pixels for unsupported code", 64'(npix), 64'd0);
        end
        // R11 recovery into a good format
        pulse_frame('h09, 1'b0);
        run_words(4);
        chk(!fmt_error && npix == 4, "R11 error clears on valid code",
            {32'(fmt_error), 32'(npix)}, {32'd0, 32'd4});

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule